// File: doc/BRIEF.md
# Subcycle Timing Edge Generator

This block paces a pattern sequencer one vector at a time. A free-running subcycle clock enable marks the base time step. The block counts these ticks into timing cycles of programmable length. Within each cycle it raises a set of drive-edge pulses and one sample-edge pulse, each at its own offset, counted in whole subcycles from the start of the cycle. A small table holds several timing sets. Each set gives a cycle length and one offset per edge. A per-vector index chooses which set the next cycle uses.

The index is read only at a cycle boundary, so the length and all edge positions of a cycle come from one set. A length below the minimum of four subcycles is raised to four. A length above the maximum is lowered to the maximum. An edge whose offset does not fit inside the cycle is never emitted, and an error level is raised for every cycle that carries such an edge. The analog pulse width and any fine delay vernier belong to other blocks. The subcycle period (for example 5 ns or 6.25 ns) is set only by the rate of the tick enable.

Top module: `subcycle_edge_gen`

## Requirements
- R1: While reset is held, and after it until a cycle has begun, all outputs are low. The first tick after reset loads the set selected by `set_idx` and emits no pulse. The next tick is the first tick of a cycle and raises `cyc_start`.
- R2: `cyc_start` pulses on the first tick of every cycle. Consecutive cycle starts are exactly the effective cycle length apart, counted in ticks.
- R3: The effective length is the written `cfg_len` clamped to the range 4 to MAX_LEN. Writes of 0 to 3 give 4. Writes above MAX_LEN give MAX_LEN (16384 by default).
- R4: Drive edge i (`cfg_ofs` bits [i*14 +: 14] by default, i = 0 to NUM_DRV-1) pulses on the tick whose position in the cycle equals its offset. The sample edge uses the next field, index NUM_DRV. Offset 0 coincides with `cyc_start`.
- R5: An edge with offset at or above the effective length never pulses. `ofs_err` is high for the whole of every cycle run with a set that has such an edge, and low for cycles whose edges all fit.
- R6: `set_idx` is taken only on the last tick of a cycle, or on the loading tick of R1. A change at any other time has no effect on the cycle in progress.
- R7: Every output pulse lasts one clock and occurs only in a clock with `sub_en` high. In clocks with `sub_en` low, all pulses are low and the cycle position holds.
- R8: A write with `cfg_we` stores length and offsets for set `cfg_sel`. A write to the set in use does not change the running cycle. It applies from the next cycle that selects that set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sub_en | input | 1 | Subcycle tick enable |
| set_idx | input | SET_W (2) | Timing set chosen for the next cycle |
| cfg_we | input | 1 | Table write strobe |
| cfg_sel | input | SET_W (2) | Table entry to write |
| cfg_len | input | LEN_W (15) | Cycle length in subcycles |
| cfg_ofs | input | (NUM_DRV+1)*CNT_W (42) | Edge offsets; drive edges low, sample edge highest |
| cyc_start | output | 1 | First tick of a cycle |
| drv_edge | output | NUM_DRV (2) | Drive-edge pulses |
| smp_edge | output | 1 | Sample-edge pulse |
| ofs_err | output | 1 | Current cycle has a suppressed edge |

## Verification
The in-line assertions are checked on every clock. They cover these rules:
- the cycle position stays below the active length and holds while no tick arrives;
- the position returns to zero after a boundary;
- the latched set stays frozen between boundaries;
- stored lengths stay inside the clamp range;
- a suppressed edge never fires;
- a cycle start never lasts two clocks.

Only the directed scenarios can show the rest:
- that each pulse lands on the exact tick its offset names;
- that clamping picks the right length;
- that a mid-cycle index change or table rewrite waits for the boundary;
- that the error level follows the set in use.

// File: rtl/tegen_pkg.sv
package tegen_pkg;
  // Shortest timing cycle the generator will run, in subcycles.
  localparam int unsigned TEG_MIN_LEN = 4;
endpackage

// File: rtl/tegen_table.sv
module tegen_table
  import tegen_pkg::*;
#(
  parameter int NUM_SETS  = 4,
  parameter int NUM_EDGES = 3,
  parameter int MAX_LEN   = 16384,
  parameter int CNT_W     = 14,
  parameter int LEN_W     = 15,
  parameter int SET_W     = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [SET_W-1:0]           wr_sel,
  input  logic [LEN_W-1:0]           wr_len,
  input  logic [NUM_EDGES*CNT_W-1:0] wr_ofs,
  input  logic [SET_W-1:0]           rd_sel,
  output logic [LEN_W-1:0]           rd_len,
  output logic [NUM_EDGES*CNT_W-1:0] rd_ofs,
  output logic [NUM_EDGES-1:0]       rd_bad
);
  localparam logic [LEN_W-1:0] LEN_LO = LEN_W'(TEG_MIN_LEN);
  localparam logic [LEN_W-1:0] LEN_HI = LEN_W'(MAX_LEN);

  // Clamping and the range test happen once, on the write path.
  logic [LEN_W-1:0]     wr_len_eff;
  logic [NUM_EDGES-1:0] wr_bad;

  always_comb begin
    if (wr_len < LEN_LO)      wr_len_eff = LEN_LO;
    else if (wr_len > LEN_HI) wr_len_eff = LEN_HI;
    else                      wr_len_eff = wr_len;
  end

  for (genvar e = 0; e < NUM_EDGES; e++) begin : g_bad
    assign wr_bad[e] = LEN_W'(wr_ofs[e*CNT_W +: CNT_W]) >= wr_len_eff;
  end

  logic [LEN_W-1:0]           len_q [NUM_SETS];
  logic [NUM_EDGES*CNT_W-1:0] ofs_q [NUM_SETS];
  logic [NUM_EDGES-1:0]       bad_q [NUM_SETS];

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    logic                       hit;
    logic [LEN_W-1:0]           len_d;
    logic [NUM_EDGES*CNT_W-1:0] ofs_d;
    logic [NUM_EDGES-1:0]       bad_d;

    assign hit = wr_en && (wr_sel == SET_W'(s));

    always_comb begin
      len_d = len_q[s];
      ofs_d = ofs_q[s];
      bad_d = bad_q[s];
      if (hit) begin
        len_d = wr_len_eff;
        ofs_d = wr_ofs;
        bad_d = wr_bad;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        len_q[s] <= LEN_LO;
        ofs_q[s] <= '0;
        bad_q[s] <= '0;
      end else begin
        len_q[s] <= len_d;
        ofs_q[s] <= ofs_d;
        bad_q[s] <= bad_d;
      end
    end
  end

  assign rd_len = len_q[rd_sel];
  assign rd_ofs = ofs_q[rd_sel];
  assign rd_bad = bad_q[rd_sel];

  AST_LEN_CLAMPED: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_len >= LEN_LO) && (rd_len <= LEN_HI)) else $error("stored length out of range"); // R3
endmodule

// File: rtl/tegen_seq.sv
module tegen_seq
  import tegen_pkg::*;
#(
  parameter int NUM_EDGES = 3,
  parameter int CNT_W     = 14,
  parameter int LEN_W     = 15
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       tick,
  input  logic [LEN_W-1:0]           nx_len,
  input  logic [NUM_EDGES*CNT_W-1:0] nx_ofs,
  input  logic [NUM_EDGES-1:0]       nx_bad,
  output logic [CNT_W-1:0]           cnt,
  output logic                       loaded,
  output logic [NUM_EDGES*CNT_W-1:0] cur_ofs,
  output logic [NUM_EDGES-1:0]       cur_bad
);
  logic [CNT_W-1:0]           cnt_q, cnt_d;
  logic                       ld_q, ld_d;
  logic [LEN_W-1:0]           len_q, len_d;
  logic [NUM_EDGES*CNT_W-1:0] ofs_q, ofs_d;
  logic [NUM_EDGES-1:0]       bad_q, bad_d;
  logic                       last, boundary;

  // The last tick of a cycle, or the first tick after reset, takes a new set.
  assign last     = (LEN_W'(cnt_q) == (len_q - LEN_W'(1)));
  assign boundary = tick && (!ld_q || last);

  always_comb begin
    cnt_d = cnt_q;
    ld_d  = ld_q;
    len_d = len_q;
    ofs_d = ofs_q;
    bad_d = bad_q;
    if (boundary) begin
      cnt_d = '0;
      ld_d  = 1'b1;
      len_d = nx_len;
      ofs_d = nx_ofs;
      bad_d = nx_bad;
    end else if (tick) begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ld_q  <= 1'b0;
      len_q <= LEN_W'(TEG_MIN_LEN);
      ofs_q <= '0;
      bad_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      ld_q  <= ld_d;
      len_q <= len_d;
      ofs_q <= ofs_d;
      bad_q <= bad_d;
    end
  end

  assign cnt     = cnt_q;
  assign loaded  = ld_q;
  assign cur_ofs = ofs_q;
  assign cur_bad = bad_q;

  AST_CNT_IN_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    ld_q |-> (LEN_W'(cnt_q) < len_q)) else $error("position past cycle end"); // R2
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    boundary |=> (cnt_q == '0) && ld_q) else $error("no wrap after boundary"); // R2
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt_q)) else $error("position moved without tick"); // R7
  AST_SET_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_q && !boundary) |=> $stable(len_q) && $stable(ofs_q) && $stable(bad_q))
    else $error("set changed mid-cycle"); // R6
endmodule

// File: rtl/tegen_edge.sv
module tegen_edge #(
  parameter int NUM_EDGES = 3,
  parameter int CNT_W     = 14
) (
  input  logic                       tick,
  input  logic                       loaded,
  input  logic [CNT_W-1:0]           cnt,
  input  logic [NUM_EDGES*CNT_W-1:0] ofs,
  input  logic [NUM_EDGES-1:0]       bad,
  output logic                       start,
  output logic [NUM_EDGES-1:0]       hit
);
  logic live;
  assign live  = tick && loaded;
  assign start = live && (cnt == '0);

  for (genvar e = 0; e < NUM_EDGES; e++) begin : g_cmp
    assign hit[e] = live && !bad[e] && (cnt == ofs[e*CNT_W +: CNT_W]);
  end
endmodule

// File: rtl/subcycle_edge_gen.sv
module subcycle_edge_gen #(
  parameter int NUM_SETS = 4,
  parameter int NUM_DRV  = 2,
  parameter int MAX_LEN  = 16384,
  localparam int SET_W     = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1,
  localparam int CNT_W     = $clog2(MAX_LEN),
  localparam int LEN_W     = $clog2(MAX_LEN + 1),
  localparam int NUM_EDGES = NUM_DRV + 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sub_en,
  input  logic [SET_W-1:0]           set_idx,
  input  logic                       cfg_we,
  input  logic [SET_W-1:0]           cfg_sel,
  input  logic [LEN_W-1:0]           cfg_len,
  input  logic [NUM_EDGES*CNT_W-1:0] cfg_ofs,
  output logic                       cyc_start,
  output logic [NUM_DRV-1:0]         drv_edge,
  output logic                       smp_edge,
  output logic                       ofs_err
);
  logic [LEN_W-1:0]           nx_len;
  logic [NUM_EDGES*CNT_W-1:0] nx_ofs, cur_ofs;
  logic [NUM_EDGES-1:0]       nx_bad, cur_bad, hit;
  logic [CNT_W-1:0]           cnt;
  logic                       loaded;

  tegen_table #(
    .NUM_SETS(NUM_SETS), .NUM_EDGES(NUM_EDGES), .MAX_LEN(MAX_LEN),
    .CNT_W(CNT_W), .LEN_W(LEN_W), .SET_W(SET_W)
  ) u_table (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_we), .wr_sel(cfg_sel), .wr_len(cfg_len), .wr_ofs(cfg_ofs),
    .rd_sel(set_idx), .rd_len(nx_len), .rd_ofs(nx_ofs), .rd_bad(nx_bad)
  );

  tegen_seq #(
    .NUM_EDGES(NUM_EDGES), .CNT_W(CNT_W), .LEN_W(LEN_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .tick(sub_en),
    .nx_len(nx_len), .nx_ofs(nx_ofs), .nx_bad(nx_bad),
    .cnt(cnt), .loaded(loaded), .cur_ofs(cur_ofs), .cur_bad(cur_bad)
  );

  tegen_edge #(
    .NUM_EDGES(NUM_EDGES), .CNT_W(CNT_W)
  ) u_edge (
    .tick(sub_en), .loaded(loaded), .cnt(cnt), .ofs(cur_ofs), .bad(cur_bad),
    .start(cyc_start), .hit(hit)
  );

  assign drv_edge = hit[NUM_DRV-1:0];
  assign smp_edge = hit[NUM_DRV];
  assign ofs_err  = loaded && (|cur_bad);

  AST_NO_SUPPRESSED_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (hit & cur_bad) == '0) else $error("out-of-cycle edge fired"); // R5
  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start |=> !cyc_start) else $error("cycle start longer than one clock"); // R7
  AST_PULSE_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (|{cyc_start, drv_edge, smp_edge}) |-> loaded) else $error("pulse before first cycle"); // R1
endmodule

// File: tb/subcycle_edge_gen_test.sv
module subcycle_edge_gen_test;
  localparam int PERIOD   = 10;
  localparam int NUM_SETS = 4;
  localparam int NUM_DRV  = 2;
  localparam int MAX_LEN  = 16384;
  localparam int SET_W    = 2;
  localparam int CNT_W    = 14;
  localparam int LEN_W    = 15;
  localparam int NE       = NUM_DRV + 1;

  logic clk, rst_n, sub_en, cfg_we;
  logic [SET_W-1:0]    set_idx, cfg_sel;
  logic [LEN_W-1:0]    cfg_len;
  logic [NE*CNT_W-1:0] cfg_ofs;
  logic                cyc_start, smp_edge, ofs_err;
  logic [NUM_DRV-1:0]  drv_edge;

  int checks = 0;
  int errors = 0;
  logic [SET_W-1:0] idx_drv = '0;

  subcycle_edge_gen #(.NUM_SETS(NUM_SETS), .NUM_DRV(NUM_DRV), .MAX_LEN(MAX_LEN)) uut (
    .clk(clk), .rst_n(rst_n), .sub_en(sub_en), .set_idx(set_idx),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_len(cfg_len), .cfg_ofs(cfg_ofs),
    .cyc_start(cyc_start), .drv_edge(drv_edge), .smp_edge(smp_edge), .ofs_err(ofs_err)
  );

  initial clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  // Outputs packed as {start, drv1, drv0, smp, err}.
  function automatic logic [4:0] outs();
    return {cyc_start, drv_edge[1], drv_edge[0], smp_edge, ofs_err};
  endfunction

  task automatic check(input string tag, input int k, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s tick %0d: actual %b expected %b", tag, k, act, exp);
    end
  endtask

  task automatic do_tick(input logic en);
    @(negedge clk);
    sub_en  = en;
    set_idx = idx_drv;
    #1;
  endtask

  task automatic apply_reset();
    rst_n = 1'b0; sub_en = 1'b0; cfg_we = 1'b0;
    cfg_sel = '0; cfg_len = '0; cfg_ofs = '0; set_idx = '0; idx_drv = '0;
    repeat (3) @(negedge clk);
    #1 check("R1 in reset", 0, outs(), 5'b0);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic cfg_write(input int sel, input int len, input int a, input int b, input int c);
    @(negedge clk);
    sub_en  = 1'b0;
    cfg_we  = 1'b1;
    cfg_sel = SET_W'(sel);
    cfg_len = LEN_W'(len);
    cfg_ofs = {CNT_W'(c), CNT_W'(b), CNT_W'(a)};
    @(negedge clk);
    cfg_we  = 1'b0;
  endtask

  // Loading tick after reset: no pulse yet.
  task automatic load_tick(input int sel);
    idx_drv = SET_W'(sel);
    do_tick(1'b0);
    check("R1 idle after reset", 0, outs(), 5'b0);
    do_tick(1'b1);
    check("R1 loading tick", 0, outs(), 5'b0);
  endtask

  // Checks ticks k0..k0+n-1 of a run with effective length L, offsets a,b,c.
  task automatic run_ticks(input int L, input int a, input int b, input int c,
                           input int k0, input int n, input int gaps, input string tag);
    for (int k = k0; k < k0 + n; k++) begin
      int p = k % L;
      logic [4:0] exp;
      for (int g = 0; g < gaps; g++) begin
        do_tick(1'b0);
        check("R7 idle clock", k, outs() & 5'b11110, 5'b0);
      end
      exp = {p == 0, p == b, p == a, p == c, (a >= L) || (b >= L) || (c >= L)};
      do_tick(1'b1);
      check(tag, k, outs(), exp);
    end
  endtask

  task automatic t_reset();
    apply_reset();
    load_tick(0);
    run_ticks(4, 0, 0, 0, 0, 5, 0, "R1 first cycle default set");
  endtask

  task automatic t_basic();
    apply_reset();
    cfg_write(0, 10, 0, 3, 7);
    load_tick(0);
    run_ticks(10, 0, 3, 7, 0, 31, 0, "R2 R4 length 10");
    apply_reset();
    cfg_write(2, 7, 6, 1, 0);
    load_tick(2);
    run_ticks(7, 6, 1, 0, 0, 22, 0, "R4 set 2 edge order");
  endtask

  task automatic t_clamp_low();
    apply_reset();
    cfg_write(1, 2, 1, 3, 5);
    load_tick(1);
    run_ticks(4, 1, 3, 5, 0, 9, 0, "R3 R5 len 2 clamps to 4");
    apply_reset();
    cfg_write(1, 0, 2, 0, 3);
    load_tick(1);
    run_ticks(4, 2, 0, 3, 0, 9, 0, "R3 len 0 clamps to 4");
  endtask

  task automatic t_clamp_high();
    apply_reset();
    cfg_write(3, MAX_LEN + 5, 0, MAX_LEN - 1, 100);
    load_tick(3);
    run_ticks(MAX_LEN, 0, MAX_LEN - 1, 100, 0, MAX_LEN + 1, 0, "R3 len clamps to max");
  endtask

  task automatic t_bad_offset();
    apply_reset();
    cfg_write(0, 6, 6, 5, 9);
    cfg_write(1, 6, 1, 2, 3);
    load_tick(0);
    run_ticks(6, 6, 5, 9, 0, 5, 0, "R5 suppressed edges");
    idx_drv = 2'd1;
    run_ticks(6, 6, 5, 9, 5, 1, 0, "R5 last bad cycle tick");
    run_ticks(6, 1, 2, 3, 0, 6, 0, "R5 error clears with good set");
  endtask

  task automatic t_switch();
    apply_reset();
    cfg_write(0, 5, 1, 2, 3);
    cfg_write(1, 8, 0, 4, 7);
    load_tick(0);
    run_ticks(5, 1, 2, 3, 0, 2, 0, "R6 set 0 start");
    idx_drv = 2'd1;
    run_ticks(5, 1, 2, 3, 2, 2, 0, "R6 mid-cycle index ignored");
    idx_drv = 2'd0;
    run_ticks(5, 1, 2, 3, 4, 5, 0, "R6 kept set 0");
    idx_drv = 2'd1;
    run_ticks(5, 1, 2, 3, 9, 1, 0, "R6 boundary tick");
    run_ticks(8, 0, 4, 7, 0, 16, 0, "R6 switched to set 1");
  endtask

  task automatic t_gaps();
    apply_reset();
    cfg_write(0, 5, 0, 2, 4);
    load_tick(0);
    run_ticks(5, 0, 2, 4, 0, 11, 2, "R7 ticks with gaps");
  endtask

  task automatic t_rewrite();
    apply_reset();
    cfg_write(0, 6, 1, 2, 3);
    load_tick(0);
    run_ticks(6, 1, 2, 3, 0, 2, 0, "R8 before rewrite");
    cfg_write(0, 4, 0, 1, 2);
    run_ticks(6, 1, 2, 3, 2, 4, 0, "R8 running cycle unchanged");
    run_ticks(4, 0, 1, 2, 0, 9, 0, "R8 new setting applied");
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_clamp_low();
    t_clamp_high();
    t_bad_offset();
    t_switch();
    t_gaps();
    t_rewrite();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule